// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Lookup Stage

This block is the lookup stage of a small L1 data cache. It is built so that choosing a set never waits on address translation. The byte offset and the set index are both taken from the low bits of the virtual address, and those bits lie inside the page offset. They are therefore the same in the virtual and the physical address, so the set is chosen as soon as a request is accepted. The tag compare is the only step that waits for the physical page number (PPN) from the translation buffer. When the PPN arrives with its strobe, the block joins it to the page offset to form the physical address. It compares the tag against every way of the chosen set and reports hit or miss with one data byte in the following cycle.

Stores are write-through without write-allocate. A store that hits updates the cached byte, and the store itself always travels on to memory outside this block. A load that misses raises a refill request carrying the physical line address. Lines come back through a fill port that writes the whole line at once. The fill port places each line by its own rule: first a way that already holds the same tag, then the lowest-numbered invalid way, and otherwise a round-robin victim kept per set. The default shape is 16 sets of 4-byte lines, 2 ways, 64-byte pages, a 12-bit physical address and a 14-bit virtual address.

Top module: `vipt_cache`

## Requirements
- R1: Reset makes every line invalid, drives req_ready to 1 and holds resp_valid and miss_valid at 0; a load after reset misses.
- R2: The byte offset is vaddr[1:0] and the set index is vaddr[5:2]; virtual address bits above the 6-bit page offset take no part in the lookup, so two virtual addresses with equal low 6 bits and the same PPN reach the same line.
- R3: req_ready is 1 only while no lookup is pending. A request is accepted on a rising edge where req_valid and req_ready are both 1, and req_ready then reads 0. ppn_valid is sampled only while a lookup is pending and is ignored while idle. resp_valid is a one-cycle pulse in the cycle right after the edge that sampled ppn_valid, and req_ready is 1 again in that same cycle.
- R4: A load hit returns the byte stored at bits [8*offset+7 : 8*offset] of the line. resp_rdata is 0 on any response that is not a load hit. Example: physical address 0x354 gives offset 0, index 0x5 and tag 0x0D, and a line holding byte 0x36 at offset 0 returns 0x36.
- R5: A load miss gives resp_hit 0 and miss_valid 1 in the response cycle, with miss_line_addr = {PPN, index} (physical address bits [11:2]).
- R6: Write-through, no write-allocate. A store hit writes req_wdata into the addressed byte and gives resp_hit 1. A store miss gives resp_hit 0, raises no miss_valid and changes no line.
- R7: A fill writes the whole line at fill_line_addr ({tag, index}) and marks it valid. Way choice, in priority order: a way already holding that tag; else the lowest-numbered invalid way; else the set's victim pointer, which starts at way 0 after reset and advances by one (wrapping) only when a valid line is evicted.
- R8: The set is associative: lines with different tags in the same set hit at the same time, and at most one way ever matches a lookup.
- R9: The tag compared is the PPN returned after the request, so the same virtual address presented with a different PPN misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Stage idle, request may be accepted |
| req_vaddr | input | 14 | Virtual address of the access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 8 | Store byte |
| ppn_valid | input | 1 | Translation result strobe |
| ppn | input | 6 | Physical page number |
| resp_valid | output | 1 | Lookup result pulse |
| resp_hit | output | 1 | Tag matched a valid way |
| resp_rdata | output | 8 | Load byte, 0 unless load hit |
| miss_valid | output | 1 | Refill request pulse on load miss |
| miss_line_addr | output | 10 | Physical line address to refill |
| fill_valid | input | 1 | Write one line |
| fill_line_addr | input | 10 | Physical line address of the fill |
| fill_data | input | 32 | Whole line, byte i at bits [8i+7:8i] |

## Verification
The checker watches the handshake on every cycle. It confirms that each response follows a sampled PPN strobe on a pending lookup, that responses are single pulses, that req_ready drops after an accept, that a refill request only goes with a load miss and a zero data byte, and that no two ways ever match at once. What the checker cannot see is what gets stored and where. That includes the byte chosen by the offset and the effect of virtual bits above the page offset. It also includes which way a fill lands in and the round-robin eviction order, whether a store hit is visible to later loads and a store miss is not, and whether reset really invalidates lines. The bench scenarios show these by comparing each response with a reference model of the sets.

// File: rtl/vipt_pkg.sv
`timescale 1ns/1ps
package vipt_pkg;

    typedef enum logic {
        LK_IDLE = 1'b0,
        LK_WAIT = 1'b1
    } lk_state_e;

    // next position of a round-robin pointer over n entries
    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/vipt_tag_array.sv
`timescale 1ns/1ps
module vipt_tag_array #(
    parameter int SETS  = 16,
    parameter int WAYS  = 2,
    parameter int TAG_W = 6,
    parameter int IDX_W = 4,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [WAYS-1:0]  hit_vec,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    output logic [WAY_W-1:0] fill_way
);
    logic [WAYS-1:0]  valid_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAY_W-1:0] vptr_q  [SETS];

    logic [WAYS-1:0] fill_match;
    logic [WAYS-1:0] fill_free;
    logic            evict;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign hit_vec[g]    = valid_q[lk_idx][g] && (tag_q[lk_idx][g] == lk_tag);
        assign fill_match[g] = valid_q[fill_idx][g] && (tag_q[fill_idx][g] == fill_tag);
        assign fill_free[g]  = !valid_q[fill_idx][g];
    end

    // placement: same tag first, then lowest invalid way, then victim pointer
    always_comb begin
        fill_way = vptr_q[fill_idx];
        evict    = 1'b1;
        if (|fill_match) begin
            evict = 1'b0;
            for (int w = WAYS - 1; w >= 0; w--)
                if (fill_match[w]) fill_way = WAY_W'(w);
        end else if (|fill_free) begin
            evict = 1'b0;
            for (int w = WAYS - 1; w >= 0; w--)
                if (fill_free[w]) fill_way = WAY_W'(w);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                vptr_q[s]  <= '0;
            end
        end else if (fill_en) begin
            valid_q[fill_idx][fill_way] <= 1'b1;
            if (evict)
                vptr_q[fill_idx] <= WAY_W'(vipt_pkg::wrap_inc(int'(vptr_q[fill_idx]), WAYS));
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_idx][fill_way] <= fill_tag;
    end

endmodule

// File: rtl/vipt_data_array.sv
`timescale 1ns/1ps
module vipt_data_array #(
    parameter int SETS       = 16,
    parameter int WAYS       = 2,
    parameter int LINE_BYTES = 4,
    parameter int IDX_W      = 4,
    parameter int OFF_W      = 2,
    parameter int WAY_W      = 1
) (
    input  logic                    clk,
    input  logic                    fill_en,
    input  logic [IDX_W-1:0]        fill_idx,
    input  logic [WAY_W-1:0]        fill_way,
    input  logic [LINE_BYTES*8-1:0] fill_line,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        acc_idx,
    input  logic [OFF_W-1:0]        acc_off,
    input  logic [WAYS-1:0]         acc_way_vec,
    input  logic [7:0]              wr_byte,
    output logic [7:0]              rd_byte
);
    localparam int LINE_W = LINE_BYTES * 8;

    logic [LINE_W-1:0] mem_q [SETS][WAYS];
    logic [7:0]        way_byte [WAYS];

    for (genvar g = 0; g < WAYS; g++) begin : g_rd
        assign way_byte[g] = mem_q[acc_idx][g][8*int'(acc_off) +: 8];
    end

    always_comb begin
        rd_byte = '0;
        for (int w = 0; w < WAYS; w++)
            if (acc_way_vec[w]) rd_byte = rd_byte | way_byte[w];
    end

    always_ff @(posedge clk) begin
        if (fill_en) mem_q[fill_idx][fill_way] <= fill_line;
        if (wr_en) begin
            for (int w = 0; w < WAYS; w++)
                if (acc_way_vec[w]) mem_q[acc_idx][w][8*int'(acc_off) +: 8] <= wr_byte;
        end
    end

endmodule

// File: rtl/vipt_lookup_ctrl.sv
`timescale 1ns/1ps
module vipt_lookup_ctrl #(
    parameter int VA_W       = 14,
    parameter int PA_W       = 12,
    parameter int PAGE_OFF_W = 6,
    parameter int OFF_W      = 2,
    parameter int IDX_W      = 4,
    parameter int TAG_W      = 6,
    parameter int WAYS       = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [VA_W-1:0]            req_vaddr,
    input  logic                       req_write,
    input  logic [7:0]                 req_wdata,
    input  logic                       ppn_valid,
    input  logic [PA_W-PAGE_OFF_W-1:0] ppn,
    input  logic [WAYS-1:0]            hit_vec,
    input  logic [7:0]                 rd_byte,
    output logic [IDX_W-1:0]           lk_idx,
    output logic [OFF_W-1:0]           lk_off,
    output logic [TAG_W-1:0]           lk_tag,
    output logic                       wr_en,
    output logic [7:0]                 wr_byte,
    output logic                       pend_write,
    output logic                       resp_valid,
    output logic                       resp_hit,
    output logic [7:0]                 resp_rdata,
    output logic                       miss_valid,
    output logic [PA_W-OFF_W-1:0]      miss_line_addr
);
    import vipt_pkg::*;

    lk_state_e             state_q;
    logic [PAGE_OFF_W-1:0] pgoff_q;
    logic                  wr_q;
    logic [7:0]            wdata_q;
    logic [PA_W-1:0]       pa;
    logic                  fire;
    logic                  hit;

    // page-offset bits are identical before and after translation
    assign lk_off  = pgoff_q[OFF_W-1:0];
    assign lk_idx  = pgoff_q[OFF_W +: IDX_W];
    assign pa      = {ppn, pgoff_q};
    assign lk_tag  = pa[PA_W-1 -: TAG_W];

    assign req_ready  = (state_q == LK_IDLE);
    assign fire       = (state_q == LK_WAIT) && ppn_valid;
    assign hit        = |hit_vec;
    assign wr_en      = fire && hit && wr_q;
    assign wr_byte    = wdata_q;
    assign pend_write = wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= LK_IDLE;
            pgoff_q        <= '0;
            wr_q           <= 1'b0;
            wdata_q        <= '0;
            resp_valid     <= 1'b0;
            resp_hit       <= 1'b0;
            resp_rdata     <= '0;
            miss_valid     <= 1'b0;
            miss_line_addr <= '0;
        end else begin
            resp_valid <= fire;
            resp_hit   <= fire && hit;
            resp_rdata <= (fire && hit && !wr_q) ? rd_byte : 8'h00;
            miss_valid <= fire && !hit && !wr_q;
            if (fire) miss_line_addr <= pa[PA_W-1:OFF_W];

            unique case (state_q)
                LK_IDLE: if (req_valid) begin
                    state_q <= LK_WAIT;
                    pgoff_q <= req_vaddr[PAGE_OFF_W-1:0];
                    wr_q    <= req_write;
                    wdata_q <= req_wdata;
                end
                LK_WAIT: if (ppn_valid) state_q <= LK_IDLE;
                default: state_q <= LK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vipt_cache.sv
`timescale 1ns/1ps
module vipt_cache #(
    parameter int VA_W       = 14,
    parameter int PA_W       = 12,
    parameter int PAGE_OFF_W = 6,
    parameter int SETS       = 16,
    parameter int WAYS       = 2,
    parameter int LINE_BYTES = 4,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(SETS),
    localparam int TAG_W     = PA_W - OFF_W - IDX_W,
    localparam int PPN_W     = PA_W - PAGE_OFF_W,
    localparam int LINE_A_W  = PA_W - OFF_W,
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [VA_W-1:0]         req_vaddr,
    input  logic                    req_write,
    input  logic [7:0]              req_wdata,
    input  logic                    ppn_valid,
    input  logic [PPN_W-1:0]        ppn,
    output logic                    resp_valid,
    output logic                    resp_hit,
    output logic [7:0]              resp_rdata,
    output logic                    miss_valid,
    output logic [LINE_A_W-1:0]     miss_line_addr,
    input  logic                    fill_valid,
    input  logic [LINE_A_W-1:0]     fill_line_addr,
    input  logic [LINE_BYTES*8-1:0] fill_data
);
    logic [IDX_W-1:0] lk_idx;
    logic [OFF_W-1:0] lk_off;
    logic [TAG_W-1:0] lk_tag;
    logic [WAYS-1:0]  hit_vec;
    logic [WAY_W-1:0] fill_way;
    logic [7:0]       rd_byte;
    logic [7:0]       wr_byte;
    logic             wr_en;
    logic             pend_write;

    vipt_lookup_ctrl #(
        .VA_W(VA_W), .PA_W(PA_W), .PAGE_OFF_W(PAGE_OFF_W),
        .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .WAYS(WAYS)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_wdata(req_wdata),
        .ppn_valid(ppn_valid), .ppn(ppn),
        .hit_vec(hit_vec), .rd_byte(rd_byte),
        .lk_idx(lk_idx), .lk_off(lk_off), .lk_tag(lk_tag),
        .wr_en(wr_en), .wr_byte(wr_byte), .pend_write(pend_write),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .miss_valid(miss_valid), .miss_line_addr(miss_line_addr)
    );

    vipt_tag_array #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_tags (
        .clk(clk), .rst(rst),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .hit_vec(hit_vec),
        .fill_en(fill_valid),
        .fill_idx(fill_line_addr[IDX_W-1:0]),
        .fill_tag(fill_line_addr[IDX_W +: TAG_W]),
        .fill_way(fill_way)
    );

    vipt_data_array #(
        .SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES),
        .IDX_W(IDX_W), .OFF_W(OFF_W), .WAY_W(WAY_W)
    ) u_data (
        .clk(clk),
        .fill_en(fill_valid),
        .fill_idx(fill_line_addr[IDX_W-1:0]),
        .fill_way(fill_way),
        .fill_line(fill_data),
        .wr_en(wr_en),
        .acc_idx(lk_idx), .acc_off(lk_off), .acc_way_vec(hit_vec),
        .wr_byte(wr_byte), .rd_byte(rd_byte)
    );

endmodule

// File: rtl/vipt_cache_chk.sv
`timescale 1ns/1ps
module vipt_cache_chk #(
    parameter int WAYS = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic            ppn_valid,
    input logic            resp_valid,
    input logic            resp_hit,
    input logic [7:0]      resp_rdata,
    input logic            miss_valid,
    input logic [WAYS-1:0] hit_vec,
    input logic            pend_write
);
    assert_resp_after_ppn_R3: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(ppn_valid && !req_ready));

    assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_resp_single_R3: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    assert_ready_with_resp_R3: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> req_ready);

    assert_miss_is_load_miss_R5: assert property (@(posedge clk) disable iff (rst)
        miss_valid |-> (resp_valid && !resp_hit && !$past(pend_write)));

    assert_no_data_unless_hit_R4: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> (resp_rdata == 8'h00));

    assert_single_way_match_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

endmodule

bind vipt_cache vipt_cache_chk #(.WAYS(WAYS)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .ppn_valid(ppn_valid), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_rdata(resp_rdata), .miss_valid(miss_valid),
    .hit_vec(hit_vec), .pend_write(pend_write)
);

// File: tb/test_vipt_cache.sv
`timescale 1ns/1ps
module test_vipt_cache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        ppn_valid = 1'b0;
    logic [5:0]  ppn = '0;
    logic        resp_valid;
    logic        resp_hit;
    logic [7:0]  resp_rdata;
    logic        miss_valid;
    logic [9:0]  miss_line_addr;
    logic        fill_valid = 1'b0;
    logic [9:0]  fill_line_addr = '0;
    logic [31:0] fill_data = '0;

    always #2.5 clk = ~clk;

    vipt_cache i_vipt_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_wdata(req_wdata),
        .ppn_valid(ppn_valid), .ppn(ppn),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .miss_valid(miss_valid), .miss_line_addr(miss_line_addr),
        .fill_valid(fill_valid), .fill_line_addr(fill_line_addr), .fill_data(fill_data)
    );

    typedef struct {
        logic       hit;
        logic [7:0] data;
        logic       miss;
        logic [9:0] addr;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 0;

    // reference model: 16 sets x 2 ways of 4-byte lines
    bit          m_valid [16][2];
    logic [5:0]  m_tag   [16][2];
    logic [31:0] m_data  [16][2];
    int          m_ptr   [16];

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < 16; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < 2; w++) m_valid[s][w] = 0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
        check(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 1);
        check(resp_valid == 1'b0, "R1 resp_valid after reset", 32'(resp_valid), 0);
        check(miss_valid == 1'b0, "R1 miss_valid after reset", 32'(miss_valid), 0);
    endtask

    task automatic do_fill(input logic [9:0] la, input logic [31:0] d);
        int s, way;
        logic [5:0] t;
        bit found;
        s = int'(la[3:0]);
        t = la[9:4];
        found = 0;
        way = 0;
        for (int w = 1; w >= 0; w--) if (m_valid[s][w] && m_tag[s][w] == t) begin way = w; found = 1; end
        if (!found) for (int w = 1; w >= 0; w--) if (!m_valid[s][w]) begin way = w; found = 1; end
        if (!found) begin way = m_ptr[s]; m_ptr[s] = (m_ptr[s] + 1) % 2; end
        m_valid[s][way] = 1;
        m_tag[s][way]   = t;
        m_data[s][way]  = d;
        @(negedge clk);
        fill_valid = 1'b1; fill_line_addr = la; fill_data = d;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic lookup(input logic [13:0] va, input logic [5:0] pp, input bit wr,
                          input logic [7:0] wd, input int dly, input string rq);
        exp_t e;
        int s, o, hw;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, {rq, " R3 busy while pending"}, 32'(req_ready), 0);
        repeat (dly) @(negedge clk);
        s  = int'(va[5:2]);
        o  = int'(va[1:0]);
        hw = -1;
        for (int w = 0; w < 2; w++) if (m_valid[s][w] && m_tag[s][w] == pp) hw = w;
        e.tag  = rq;
        e.hit  = (hw >= 0);
        e.data = 8'h00;
        e.miss = 1'b0;
        e.addr = {pp, va[5:2]};
        if (hw >= 0 && !wr) e.data = m_data[s][hw][8*o +: 8];
        if (hw >= 0 && wr)  m_data[s][hw][8*o +: 8] = wd;
        if (hw < 0 && !wr)  e.miss = 1'b1;
        exp_q.push_back(e);
        ppn_valid = 1'b1; ppn = pp;
        @(negedge clk);
        ppn_valid = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, {rq, " R3 response one cycle after PPN"}, 32'(exp_q.size()), 0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(resp_hit == e.hit, {e.tag, " hit"}, 32'(resp_hit), 32'(e.hit));
                check(resp_rdata == e.data, {e.tag, " data"}, 32'(resp_rdata), 32'(e.data));
                check(miss_valid == e.miss, {e.tag, " refill request"}, 32'(miss_valid), 32'(e.miss));
                if (e.miss)
                    check(miss_line_addr == e.addr, {e.tag, " refill line address"},
                          32'(miss_line_addr), 32'(e.addr));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R3 watchdog expired", 0, 1);
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        lookup(14'h03D4, 6'h0D, 0, 8'h00, 1, "R1 R5 cold load miss");
        do_fill(10'h0D5, 32'h1DF07236);
        lookup(14'h03D4, 6'h0D, 0, 8'h00, 2, "R4 R7 hit byte 0x36");
        lookup(14'h03D6, 6'h0D, 0, 8'h00, 0, "R4 offset 2");
        lookup(14'h1FD5, 6'h0D, 0, 8'h00, 3, "R2 high VA bits ignored");
        lookup(14'h03D4, 6'h0E, 0, 8'h00, 1, "R9 other PPN misses");
        do_fill(10'h0E5, 32'hAABBCCDD);
        lookup(14'h03D7, 6'h0E, 0, 8'h00, 1, "R8 second way hit");
        lookup(14'h03D4, 6'h0D, 0, 8'h00, 1, "R8 first way still hit");
        do_fill(10'h0F5, 32'h44332211);
        lookup(14'h03D4, 6'h0D, 0, 8'h00, 1, "R7 victim way0 evicted");
        lookup(14'h03D5, 6'h0F, 0, 8'h00, 1, "R7 new line hit");
        lookup(14'h03D4, 6'h0E, 0, 8'h00, 1, "R7 way1 kept");
        do_fill(10'h0E5, 32'h01020304);
        lookup(14'h03D4, 6'h0E, 0, 8'h00, 1, "R7 same-tag fill replaces in place");
        lookup(14'h03D4, 6'h0F, 0, 8'h00, 1, "R7 same-tag fill evicts nothing");
        do_fill(10'h0D5, 32'h1DF07236);
        lookup(14'h03D4, 6'h0E, 0, 8'h00, 1, "R7 round-robin evicts way1");
        lookup(14'h03D4, 6'h0F, 0, 8'h00, 0, "R7 way0 line kept");
        lookup(14'h03D7, 6'h0F, 1, 8'hA5, 1, "R6 store hit");
        lookup(14'h03D7, 6'h0F, 0, 8'h00, 1, "R6 store visible");
        lookup(14'h03D4, 6'h0F, 0, 8'h00, 1, "R6 other bytes unchanged");
        lookup(14'h0010, 6'h20, 1, 8'h5A, 1, "R6 store miss no refill");
        lookup(14'h0010, 6'h20, 0, 8'h00, 1, "R6 no write-allocate");
        // PPN strobe while idle must be ignored
        @(negedge clk);
        ppn_valid = 1'b1; ppn = 6'h0F;
        @(negedge clk);
        ppn_valid = 1'b0;
        check(resp_valid == 1'b0, "R3 idle PPN strobe ignored", 32'(resp_valid), 0);
        @(negedge clk);
        check(resp_valid == 1'b0, "R3 idle PPN strobe ignored later", 32'(resp_valid), 0);
        check(req_ready == 1'b1, "R3 still idle", 32'(req_ready), 1);
        lookup(14'h2FD4, 6'h0D, 0, 8'h00, 5, "R2 R3 long translation");
        do_reset();
        lookup(14'h03D4, 6'h0F, 0, 8'h00, 1, "R1 reset invalidates lines");
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 all responses seen", 32'(exp_q.size()), 0);
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule